// File: doc/BRIEF.md
# Subroutine Call and Return Stack

This unit keeps the return state of a small 8-bit controller core. It watches each decoded instruction, given as an opcode byte and the byte that follows it, whenever the opcode strobe is high. Absolute jumps and calls load a new 12-bit program counter. The low 11 bits of that counter come from the instruction and the top bit comes from a program-memory bank latch. A call also pushes the return address and the upper status nibble (carry, auxiliary carry, user flag, register-bank select) into an eight-entry on-chip stack.

There are two kinds of return. The plain return pops the stack and restores only the program counter. The full return also restores the saved status nibble and raises a one-cycle pulse that tells the interrupt logic it may accept requests again. The stack pointer lives in the low three bits of the status word, and bit 3 of that word reads as one. Every output is registered, so each result appears on the clock edge that samples the instruction.

Top module: `subr_stack`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `pc_out`=0, `psw_out`=8'h08, `pc_load`=0 and `irq_rearm`=0. The stack pointer is 0 and bank 0 is selected.
- R2: An accepted opcode whose bits 4:0 are 5'b00100 is a jump. After the edge, `pc_out` = {bank, opcode[7:5], `op_arg`} and `pc_load`=1 for one cycle. The stack pointer is unchanged.
- R3: An accepted opcode whose bits 4:0 are 5'b10100 is a call. It writes {`psw_in`[7:4], `ret_pc`} to the entry at the current stack pointer, increments the pointer, and loads the target exactly as in R2.
- R4: Opcode 8'h83 is the plain return. It decrements the pointer, loads `pc_out` from the 12 PC bits of the entry at the new pointer, and pulses `pc_load`. `psw_out`[7:4] follows `psw_in`[7:4] as in R9.
- R5: Opcode 8'h93 is the full return. It behaves as R4, and in addition `psw_out`[7:4] takes the saved nibble and `irq_rearm` is 1 for exactly that one cycle.
- R6: Opcode 8'hE5 selects bank 0 and 8'hF5 selects bank 1. A bank selection leaves `pc_out`, `pc_load` and the stack pointer unchanged and takes effect from the next jump or call.
- R7: A return restores all 12 saved PC bits, including bit 11, whatever the current bank selection is.
- R8: The stack pointer appears on `psw_out`[2:0] and wraps modulo 8. A ninth nested call overwrites the oldest entry, and a return from pointer 0 reads entry 7.
- R9: `psw_out`[3] is always 1. Outside a full return, `psw_out`[7:4] equals `psw_in`[7:4] from the previous edge. `psw_in`[3:0] has no effect.
- R10: When `op_valid` is low, or the opcode is none of the above, `pc_load` and `irq_rearm` stay 0 and `pc_out` and the stack pointer hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 8 | First instruction byte |
| op_arg | input | 8 | Second instruction byte (low target bits) |
| ret_pc | input | 12 | Address of the instruction after the call |
| psw_in | input | 8 | Current status word; bits 7:4 are saved on a call |
| psw_out | output | 8 | {status nibble, 1, stack pointer} |
| pc_out | output | 12 | Program counter to load |
| pc_load | output | 1 | One-cycle pulse when `pc_out` was just loaded |
| irq_rearm | output | 1 | One-cycle pulse after a full return |

## Verification
A stack pointer that is off by one shows up at once on `psw_out`[2:0]. A wrong saved entry stays hidden until the matching return, and then shows as a wrong `pc_out` or status nibble on the cycle after that return. A bank latch in the wrong state only shows on the next jump or call, as a wrong bit 11. The bench therefore nests nine calls and then unwinds them through both kinds of return, so that every stack entry is written, overwritten and read back at the ports.

// File: rtl/subr_stack_pkg.sv
package subr_stack_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_JMP, K_CALL, K_RET, K_RETR, K_BANK0, K_BANK1
  } op_kind_e;

  localparam logic [4:0] LOW_JMP  = 5'b00100;
  localparam logic [4:0] LOW_CALL = 5'b10100;
  localparam logic [7:0] OPC_RET   = 8'h83;
  localparam logic [7:0] OPC_RETR  = 8'h93;
  localparam logic [7:0] OPC_BANK0 = 8'hE5;
  localparam logic [7:0] OPC_BANK1 = 8'hF5;
endpackage

// File: rtl/subr_decode.sv
module subr_decode
  import subr_stack_pkg::*;
(
  input  logic       valid,
  input  logic [7:0] opcode,
  output op_kind_e   kind
);
  always_comb begin
    kind = K_NONE;
    if (valid) begin
      if (opcode[4:0] == LOW_JMP)       kind = K_JMP;
      else if (opcode[4:0] == LOW_CALL) kind = K_CALL;
      else if (opcode == OPC_RET)       kind = K_RET;
      else if (opcode == OPC_RETR)      kind = K_RETR;
      else if (opcode == OPC_BANK0)     kind = K_BANK0;
      else if (opcode == OPC_BANK1)     kind = K_BANK1;
    end
  end
endmodule

// File: rtl/subr_stack_ram.sv
module subr_stack_ram #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/subr_stack.sv
module subr_stack
  import subr_stack_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int SP_W  = 3,
  parameter int NIB_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [7:0]      op_code,
  input  logic [7:0]      op_arg,
  input  logic [PC_W-1:0] ret_pc,
  input  logic [7:0]      psw_in,
  output logic [7:0]      psw_out,
  output logic [PC_W-1:0] pc_out,
  output logic            pc_load,
  output logic            irq_rearm
);
  localparam int WORD_W = PC_W + NIB_W;
  localparam int PAGE_W = PC_W - 1;

  op_kind_e          kind;
  logic [SP_W-1:0]   sp_q;
  logic [SP_W-1:0]   sp_dec;
  logic              bank_q;
  logic [NIB_W-1:0]  nib_q;
  logic [PC_W-1:0]   pc_q;
  logic              load_q;
  logic              rearm_q;
  logic [WORD_W-1:0] rd_word;
  logic [PC_W-1:0]   target;

  subr_decode u_dec (
    .valid  (op_valid),
    .opcode (op_code),
    .kind   (kind)
  );

  assign sp_dec = sp_q - 1'b1;
  assign target = {bank_q, op_code[7:5], op_arg};

  subr_stack_ram #(.WORD_W(WORD_W), .ADDR_W(SP_W)) u_ram (
    .clk   (clk),
    .we    (kind == K_CALL),
    .waddr (sp_q),
    .wdata ({psw_in[7:8-NIB_W], ret_pc}),
    .raddr (sp_dec),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= '0;
      bank_q  <= 1'b0;
      nib_q   <= '0;
      pc_q    <= '0;
      load_q  <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      load_q  <= 1'b0;
      rearm_q <= 1'b0;
      nib_q   <= psw_in[7:8-NIB_W];
      unique case (kind)
        K_JMP: begin
          pc_q   <= target;
          load_q <= 1'b1;
        end
        K_CALL: begin
          pc_q   <= target;
          sp_q   <= sp_q + 1'b1;
          load_q <= 1'b1;
        end
        K_RET: begin
          pc_q   <= rd_word[PC_W-1:0];
          sp_q   <= sp_dec;
          load_q <= 1'b1;
        end
        K_RETR: begin
          pc_q    <= rd_word[PC_W-1:0];
          sp_q    <= sp_dec;
          nib_q   <= rd_word[WORD_W-1:PC_W];
          load_q  <= 1'b1;
          rearm_q <= 1'b1;
        end
        K_BANK0: bank_q <= 1'b0;
        K_BANK1: bank_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign psw_out   = {nib_q, 1'b1, sp_q};
  assign pc_out    = pc_q;
  assign pc_load   = load_q;
  assign irq_rearm = rearm_q;

  if (PAGE_W != 11) begin : g_bad_width
    initial $error("subr_stack: PC_W must be 12");
  end
endmodule

// File: rtl/subr_stack_chk.sv
module subr_stack_chk (
  input logic        clk,
  input logic        rst,
  input logic        op_valid,
  input logic [7:0]  op_code,
  input logic [7:0]  op_arg,
  input logic [11:0] ret_pc,
  input logic [7:0]  psw_in,
  input logic [7:0]  psw_out,
  input logic [11:0] pc_out,
  input logic        pc_load,
  input logic        irq_rearm
);
  a_r2_jump_target: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code[4:0] == 5'b00100) |=>
      (pc_load && pc_out[10:0] == $past({op_code[7:5], op_arg})
       && psw_out[2:0] == $past(psw_out[2:0])));

  a_r3_call_push: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code[4:0] == 5'b10100) |=>
      (psw_out[2:0] == $past(psw_out[2:0]) + 3'd1));

  a_r4_ret_pop: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 8'h83 || op_code == 8'h93)) |=>
      (pc_load && psw_out[2:0] == $past(psw_out[2:0]) - 3'd1));

  a_r5_rearm_src: assert property (@(posedge clk) disable iff (rst)
    irq_rearm |-> $past(op_valid && op_code == 8'h93));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!pc_load && !irq_rearm && $stable(pc_out)
                   && $stable(psw_out[2:0])));
endmodule

bind subr_stack subr_stack_chk u_chk (.*);

// File: tb/test_subr_stack.sv
module test_subr_stack;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [7:0]  op_code = '0;
  logic [7:0]  op_arg = '0;
  logic [11:0] ret_pc = '0;
  logic [7:0]  psw_in = '0;
  logic [7:0]  psw_out;
  logic [11:0] pc_out;
  logic        pc_load;
  logic        irq_rearm;

  always #(CLK_PERIOD/2) clk = ~clk;

  subr_stack i_subr_stack (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_arg(op_arg), .ret_pc(ret_pc), .psw_in(psw_in), .psw_out(psw_out),
    .pc_out(pc_out), .pc_load(pc_load), .irq_rearm(irq_rearm)
  );

  typedef struct {
    logic [11:0] pc;
    logic [7:0]  psw;
    logic        ld;
    logic        rearm;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [2:0]  m_sp = '0;
  logic        m_bank = 1'b0;
  logic [11:0] m_pc = '0;
  logic [15:0] m_stk [8];

  task automatic step(input logic v, input logic [7:0] op, input logic [7:0] arg,
                      input logic [11:0] npc, input logic [7:0] psw, input string tag);
    exp_t e;
    logic [2:0] ra;
    logic [3:0] nib;
    ra = m_sp - 3'd1;
    nib = psw[7:4];
    e.ld = 1'b0;
    e.rearm = 1'b0;
    e.tag = tag;
    if (v) begin
      if (op[4:0] == 5'b00100) begin
        m_pc = {m_bank, op[7:5], arg}; e.ld = 1'b1;
      end else if (op[4:0] == 5'b10100) begin
        m_stk[m_sp] = {psw[7:4], npc};
        m_sp = m_sp + 3'd1;
        m_pc = {m_bank, op[7:5], arg}; e.ld = 1'b1;
      end else if (op == 8'h83) begin
        m_pc = m_stk[ra][11:0]; m_sp = ra; e.ld = 1'b1;
      end else if (op == 8'h93) begin
        m_pc = m_stk[ra][11:0]; m_sp = ra; nib = m_stk[ra][15:12];
        e.ld = 1'b1; e.rearm = 1'b1;
      end else if (op == 8'hE5) m_bank = 1'b0;
      else if (op == 8'hF5) m_bank = 1'b1;
    end
    e.pc = m_pc;
    e.psw = {nib, 1'b1, m_sp};
    @(negedge clk);
    op_valid = v; op_code = op; op_arg = arg; ret_pc = npc; psw_in = psw;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (pc_out !== e.pc || psw_out !== e.psw || pc_load !== e.ld || irq_rearm !== e.rearm) begin
        fails++;
        $display("FAIL %s: pc=%h psw=%h ld=%b rearm=%b expected pc=%h psw=%h ld=%b rearm=%b",
                 e.tag, pc_out, psw_out, pc_load, irq_rearm, e.pc, e.psw, e.ld, e.rearm);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (pc_out !== 12'h000 || psw_out !== 8'h08 || pc_load !== 1'b0 || irq_rearm !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: pc=%h psw=%h ld=%b rearm=%b expected pc=000 psw=08 ld=0 rearm=0",
               pc_out, psw_out, pc_load, irq_rearm);
    end
    step(0, 8'h00, 8'h00, 12'h000, 8'hA5, "R9 low psw bits ignored");
    step(1, 8'hA4, 8'h3C, 12'h000, 8'hA0, "R2 jump bank0");
    step(1, 8'hF5, 8'h00, 12'h000, 8'hA0, "R6 select bank1 no load");
    step(1, 8'h74, 8'h12, 12'h53E, 8'h50, "R3 call bank1");
    step(1, 8'hE5, 8'h00, 12'h000, 8'h20, "R6 select bank0");
    step(1, 8'h14, 8'h40, 12'hB14, 8'h30, "R3 second call");
    step(1, 8'h83, 8'h00, 12'h000, 8'hC0, "R7 ret keeps bit 11, R4 nibble not restored");
    step(1, 8'h93, 8'h00, 12'h000, 8'hC0, "R5 full return restores nibble");
    step(0, 8'h83, 8'h00, 12'h000, 8'hC0, "R10 strobe low");
    step(1, 8'h00, 8'h00, 12'h000, 8'hC0, "R10 unknown opcode");
    step(1, 8'hF5, 8'h00, 12'h000, 8'h00, "R6 bank1 again");
    step(1, 8'hE4, 8'hFF, 12'h000, 8'h00, "R2 jump bank1");
    step(1, 8'hE5, 8'h00, 12'h000, 8'h00, "R6 bank0");
    for (int i = 0; i < 9; i++)
      step(1, {3'(i), 5'b10100}, 8'(i * 7), 12'(12'h100 + 12'(i * 17)),
           {4'(i + 3), 4'h0}, "R8 nested call wrap");
    for (int i = 0; i < 9; i++)
      step(1, (i % 2 == 0) ? 8'h93 : 8'h83, 8'h00, 12'h000, 8'hF0,
           "R8 unwind through wrap");
    step(0, 8'h00, 8'h00, 12'h000, 8'h00, "R10 idle tail");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule